// File: doc/BRIEF.md
# Phase Edge Search Controller

This controller brings a derived clock into phase with a bus clock. It drives a 6-bit phase setting into an external phase shifter and reads back one bit from an external phase comparator. Every time it changes the setting, it waits a fixed settle time and then toggles a load strobe. It samples the comparator only after that toggle.

The controller first hunts for a falling comparator transition: the comparator changed between two samples and now reads 0. It then tests that edge in three passes.
- Forward pass: step forward while the comparator stays 0.
- Backward pass: step back while it stays 0.
- Retreat pass: step back a fixed number of times, after which the comparator must read 1.

If any pass fails, the attempt is thrown away and a new hunt begins from the last phase that was written. Once the edge is confirmed, the hunt runs again from the retreat point. The controller then parks the phase one step below the edge it finds, loading it with one extra strobe toggle.

A start pulse begins the sequence from the current phase. On completion the controller reports either done, with the number of probes it spent, or fail.

Top module: `phase_edge_align`

## Requirements
- R1: After reset the outputs are as follows: phase_o = 0, load_o = 0, busy_o = 0, done_o = 0, fail_o = 0 and adj_count_o = 0.
- R2: A probe is one comparator sample. For every probe:
  - phase_o moves by at most one step, modulo 64.
  - phase_o then stays stable for at least SETTLE_CYC (5) clock cycles before load_o toggles.
  - The comparator is sampled after the toggle.
  - Each probe adds one to adj_count_o.
- R3: During a hunt, a probe that reads 1 makes the next probe one step higher, and a probe that reads 0 makes the next probe one step lower. The hunt stops on the first probe that reads 0 when the previous sample read 1.
- R4: After the first hunt, the forward pass probes up to 5 increasing phases. The first of these is the edge phase itself. If the comparator reads 1 before the fifth forward probe, the attempt is discarded.
- R5: The backward pass probes up to 3 decreasing phases. It discards the attempt in either of two cases:
  - the forward pass ended on a 1;
  - a 1 is read before the third backward probe.
- R6: The retreat pass probes 5 more decreasing phases. If the last of them reads 0, the attempt is discarded. If it reads 1, a second hunt starts, probing the same phase first.
- R7: When the second hunt finds its falling edge, the phase becomes the edge phase minus 1 (mod 64). This setting is written with one more strobe toggle that is not counted. done_o is then set and busy_o falls.
- R8: A discarded attempt restarts the hunt from the last written phase. When the tenth attempt is discarded, fail_o is set instead and done_o stays 0.
- R9: If adj_count_o reaches MAX_ADJ (default 65535), the controller stops with fail_o set, whatever the probe's outcome.
- R10: start_i clears done_o, fail_o and adj_count_o, and the hunt begins from the current phase_o.
- R11: Phase steps wrap modulo 64, so stepping down from 0 gives 63.
- R12: start_i while busy_o is high has no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an alignment run |
| cmp_i | input | 1 | Phase comparator result |
| phase_o | output | PHASE_W | Phase setting to the shifter |
| load_o | output | 1 | Load strobe, toggled once per write |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run succeeded |
| fail_o | output | 1 | Run gave up |
| adj_count_o | output | CNT_W | Probes spent in the last run |

## Verification
Some probe samples settle two outcomes at once. In one case, a sample both discards an attempt and uses up the attempt budget. An alternating comparator pattern produces exactly this: a false edge on every attempt, so the tenth discard lands on the 40th probe. In another case, the adjustment budget runs out on a probe that would otherwise continue the hunt. A second instance with MAX_ADJ = 8 produces this on a long hunt. In both cases the limit must win: fail_o is set, done_o stays low, and adj_count_o equals the exact predicted probe count.

// File: rtl/phase_edge_pkg.sv
package phase_edge_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ISSUE, ST_WAIT, ST_FIN_ISSUE, ST_FIN_WAIT
  } seq_st_e;

  typedef enum logic [2:0] {
    SG_HUNT, SG_FWD, SG_BACK, SG_RETREAT, SG_REHUNT
  } stage_e;

  typedef enum logic [1:0] {
    PR_IDLE, PR_SETTLE, PR_SAMPLE
  } probe_st_e;
endpackage

// File: rtl/phase_probe.sv
module phase_probe
  import phase_edge_pkg::*;
#(
  parameter int PHASE_W     = 6,
  parameter int SETTLE_CYC  = 5,
  parameter int RESET_PHASE = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [PHASE_W-1:0] target_i,
  input  logic               cmp_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic               load_o,
  output logic               ack_o,
  output logic               sample_o
);
  localparam int CW = $clog2(SETTLE_CYC + 1);

  probe_st_e          st_q;
  logic [CW-1:0]      cnt_q;
  logic [PHASE_W-1:0] phase_q;
  logic               load_q, ack_q, smp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= PR_IDLE;
      cnt_q   <= '0;
      phase_q <= PHASE_W'(RESET_PHASE);
      load_q  <= 1'b0;
      ack_q   <= 1'b0;
      smp_q   <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      case (st_q)
        PR_IDLE: if (req_i) begin
          phase_q <= target_i;
          cnt_q   <= CW'(SETTLE_CYC - 1);
          st_q    <= PR_SETTLE;
        end
        PR_SETTLE: begin
          if (cnt_q == '0) begin
            load_q <= ~load_q;
            st_q   <= PR_SAMPLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PR_SAMPLE: begin
          smp_q <= cmp_i;
          ack_q <= 1'b1;
          st_q  <= PR_IDLE;
        end
        default: st_q <= PR_IDLE;
      endcase
    end
  end

  assign phase_o  = phase_q;
  assign load_o   = load_q;
  assign ack_o    = ack_q;
  assign sample_o = smp_q;
endmodule

// File: rtl/phase_budget.sv
module phase_budget #(
  parameter int CNT_W        = 16,
  parameter int MAX_ADJ      = 65535,
  parameter int MAX_ATTEMPTS = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adj_inc_i,
  input  logic             att_inc_i,
  output logic [CNT_W-1:0] adj_o,
  output logic             adj_hit_o,
  output logic             att_hit_o
);
  localparam int AW = $clog2(MAX_ATTEMPTS + 1);

  logic [CNT_W-1:0] adj_q;
  logic [AW-1:0]    att_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adj_q <= '0;
      att_q <= '0;
    end else if (clr_i) begin
      adj_q <= '0;
      att_q <= '0;
    end else begin
      if (adj_inc_i) adj_q <= adj_q + 1'b1;
      if (att_inc_i) att_q <= att_q + 1'b1;
    end
  end

  // asserted when the increment in progress reaches the limit
  assign adj_hit_o = adj_q >= CNT_W'(MAX_ADJ - 1);
  assign att_hit_o = att_q >= AW'(MAX_ATTEMPTS - 1);
  assign adj_o     = adj_q;
endmodule

// File: rtl/phase_seq.sv
module phase_seq
  import phase_edge_pkg::*;
#(
  parameter int PHASE_W       = 6,
  parameter int FWD_STEPS     = 5,
  parameter int BACK_STEPS    = 3,
  parameter int RETREAT_STEPS = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [PHASE_W-1:0] cur_phase_i,
  input  logic               cmp_i,
  input  logic               ack_i,
  input  logic               sample_i,
  input  logic               adj_hit_i,
  input  logic               att_hit_i,
  output logic               req_o,
  output logic [PHASE_W-1:0] target_o,
  output logic               clr_o,
  output logic               adj_inc_o,
  output logic               att_inc_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               fail_o
);
  localparam int MAXS_A = (FWD_STEPS > BACK_STEPS) ? FWD_STEPS : BACK_STEPS;
  localparam int MAXS   = (MAXS_A > RETREAT_STEPS) ? MAXS_A : RETREAT_STEPS;
  localparam int SW     = $clog2(MAXS + 1);

  seq_st_e            st_q, st_d;
  stage_e             stage_q, stage_d;
  logic [PHASE_W-1:0] p_q, p_d, w_q, w_d, step_tgt;
  logic               prev_q, prev_d, done_q, done_d, fail_q, fail_d, restart;
  logic [SW-1:0]      steps_q, steps_d, cnt_n;

  always_comb begin
    case (stage_q)
      SG_FWD:              step_tgt = p_q + 1'b1;
      SG_BACK, SG_RETREAT: step_tgt = p_q - 1'b1;
      default:             step_tgt = p_q;
    endcase
  end

  assign target_o = (st_q == ST_FIN_ISSUE) ? p_q : step_tgt;
  assign req_o    = (st_q == ST_ISSUE) || (st_q == ST_FIN_ISSUE);
  assign cnt_n    = steps_q + 1'b1;

  always_comb begin
    st_d      = st_q;
    stage_d   = stage_q;
    p_d       = p_q;
    w_d       = w_q;
    prev_d    = prev_q;
    steps_d   = steps_q;
    done_d    = done_q;
    fail_d    = fail_q;
    clr_o     = 1'b0;
    adj_inc_o = 1'b0;
    att_inc_o = 1'b0;
    restart   = 1'b0;
    case (st_q)
      ST_IDLE: if (start_i) begin
        p_d     = cur_phase_i;
        prev_d  = cmp_i;
        stage_d = SG_HUNT;
        steps_d = '0;
        done_d  = 1'b0;
        fail_d  = 1'b0;
        clr_o   = 1'b1;
        st_d    = ST_ISSUE;
      end
      ST_ISSUE: begin
        p_d  = step_tgt;
        w_d  = step_tgt;
        st_d = ST_WAIT;
      end
      ST_WAIT: if (ack_i) begin
        adj_inc_o = 1'b1;
        if (adj_hit_i) begin
          fail_d = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          st_d = ST_ISSUE;
          case (stage_q)
            SG_HUNT, SG_REHUNT: begin
              p_d    = sample_i ? w_q + 1'b1 : w_q - 1'b1;
              prev_d = sample_i;
              if (prev_q && !sample_i) begin
                steps_d = '0;
                if (stage_q == SG_REHUNT) st_d = ST_FIN_ISSUE;
                else stage_d = SG_FWD;
              end
            end
            SG_FWD: begin
              if (sample_i) restart = 1'b1;
              else if (cnt_n == SW'(FWD_STEPS)) begin
                stage_d = SG_BACK;
                steps_d = '0;
              end else steps_d = cnt_n;
            end
            SG_BACK: begin
              if (cnt_n == SW'(BACK_STEPS)) begin
                stage_d = SG_RETREAT;
                steps_d = '0;
              end else if (sample_i) restart = 1'b1;
              else steps_d = cnt_n;
            end
            SG_RETREAT: begin
              if (cnt_n == SW'(RETREAT_STEPS)) begin
                if (sample_i) begin
                  stage_d = SG_REHUNT;
                  prev_d  = 1'b1;
                  steps_d = '0;
                end else restart = 1'b1;
              end else steps_d = cnt_n;
            end
            default: restart = 1'b1;
          endcase
        end
      end
      ST_FIN_ISSUE: st_d = ST_FIN_WAIT;
      ST_FIN_WAIT: if (ack_i) begin
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
    if (restart) begin
      if (att_hit_i) begin
        fail_d = 1'b1;
        st_d   = ST_IDLE;
      end else begin
        att_inc_o = 1'b1;
        stage_d   = SG_HUNT;
        steps_d   = '0;
        prev_d    = sample_i;
        p_d       = w_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      stage_q <= SG_HUNT;
      p_q     <= '0;
      w_q     <= '0;
      prev_q  <= 1'b0;
      steps_q <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      stage_q <= stage_d;
      p_q     <= p_d;
      w_q     <= w_d;
      prev_q  <= prev_d;
      steps_q <= steps_d;
      done_q  <= done_d;
      fail_q  <= fail_d;
    end
  end

  assign busy_o = st_q != ST_IDLE;
  assign done_o = done_q;
  assign fail_o = fail_q;
endmodule

// File: rtl/phase_edge_align.sv
module phase_edge_align #(
  parameter int PHASE_W       = 6,
  parameter int CNT_W         = 16,
  parameter int SETTLE_CYC    = 5,
  parameter int MAX_ATTEMPTS  = 10,
  parameter int MAX_ADJ       = 65535,
  parameter int FWD_STEPS     = 5,
  parameter int BACK_STEPS    = 3,
  parameter int RETREAT_STEPS = 5,
  parameter int RESET_PHASE   = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               cmp_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic               load_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               fail_o,
  output logic [CNT_W-1:0]   adj_count_o
);
  logic               req, ack, smp, clr, adj_inc, att_inc, adj_hit, att_hit;
  logic [PHASE_W-1:0] target;

  phase_seq #(
    .PHASE_W(PHASE_W), .FWD_STEPS(FWD_STEPS),
    .BACK_STEPS(BACK_STEPS), .RETREAT_STEPS(RETREAT_STEPS)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .cur_phase_i(phase_o), .cmp_i(cmp_i), .ack_i(ack), .sample_i(smp),
    .adj_hit_i(adj_hit), .att_hit_i(att_hit), .req_o(req), .target_o(target),
    .clr_o(clr), .adj_inc_o(adj_inc), .att_inc_o(att_inc),
    .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o)
  );

  phase_probe #(
    .PHASE_W(PHASE_W), .SETTLE_CYC(SETTLE_CYC), .RESET_PHASE(RESET_PHASE)
  ) u_probe (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req), .target_i(target),
    .cmp_i(cmp_i), .phase_o(phase_o), .load_o(load_o),
    .ack_o(ack), .sample_o(smp)
  );

  phase_budget #(
    .CNT_W(CNT_W), .MAX_ADJ(MAX_ADJ), .MAX_ATTEMPTS(MAX_ATTEMPTS)
  ) u_budget (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .adj_inc_i(adj_inc),
    .att_inc_i(att_inc), .adj_o(adj_count_o), .adj_hit_o(adj_hit),
    .att_hit_o(att_hit)
  );
endmodule

// File: rtl/phase_edge_align_chk.sv
module phase_edge_align_chk #(
  parameter int PHASE_W     = 6,
  parameter int CNT_W       = 16,
  parameter int SETTLE_CYC  = 5,
  parameter int RESET_PHASE = 0
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [PHASE_W-1:0] phase_o,
  input logic               load_o,
  input logic               busy_o,
  input logic               done_o,
  input logic               fail_o,
  input logic [CNT_W-1:0]   adj_count_o
);
  localparam int GW = $clog2(SETTLE_CYC + 2);

  logic [PHASE_W-1:0] ph_seen_q;
  logic [GW-1:0]      since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_seen_q <= PHASE_W'(RESET_PHASE);
      since_q   <= GW'(SETTLE_CYC);
    end else begin
      ph_seen_q <= phase_o;
      if (phase_o != ph_seen_q) since_q <= GW'(1);
      else if (since_q < GW'(SETTLE_CYC)) since_q <= since_q + 1'b1;
    end
  end

  // R2
  settle_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(load_o) |-> since_q >= GW'(SETTLE_CYC));

  // R2
  phase_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(phase_o) |-> (PHASE_W'(phase_o - $past(phase_o)) == PHASE_W'(1) ||
                           PHASE_W'(phase_o - $past(phase_o)) == '1));

  // R2
  strobe_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(load_o) |-> busy_o);

  // R8
  done_fail_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));

  // R10
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(adj_count_o) |-> (adj_count_o == $past(adj_count_o) + 1'b1 ||
                               adj_count_o == '0));

  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind phase_edge_align phase_edge_align_chk #(
  .PHASE_W(PHASE_W), .CNT_W(CNT_W), .SETTLE_CYC(SETTLE_CYC),
  .RESET_PHASE(RESET_PHASE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .phase_o(phase_o), .load_o(load_o),
  .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
  .adj_count_o(adj_count_o)
);

// File: tb/phase_edge_align_test.sv
module phase_edge_align_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       cmp;
  logic [5:0] phase;
  logic       load, busy, done, fail;
  logic [15:0] adj;

  logic       start_l = 1'b0;
  logic       cmp_l, load_l, busy_l, done_l, fail_l;
  logic [5:0] phase_l;
  logic [15:0] adj_l;

  int n_chk = 0;
  int n_bad = 0;
  int tog = 0;

  // comparator model
  int         mode = 0;
  logic [5:0] edge_ph = 6'd20;
  logic [5:0] glitch_ph = 6'd0;
  logic       glitch_en = 1'b0;
  logic       noisy_en = 1'b0;
  logic [5:0] rel, rel_l;

  always #2 clk = ~clk;

  always_comb begin
    rel = phase - edge_ph;
    if (mode == 1) cmp = ~phase[0];
    else begin
      cmp = rel[5];
      if (glitch_en && phase == glitch_ph) cmp = 1'b0;
      if (noisy_en && tog == 9 && phase == edge_ph + 6'd2) cmp = 1'b1;
    end
  end

  always_comb begin
    rel_l = phase_l - 6'd20;
    cmp_l = rel_l[5];
  end

  always @(load) tog = tog + 1;

  phase_edge_align uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmp_i(cmp),
    .phase_o(phase), .load_o(load), .busy_o(busy), .done_o(done),
    .fail_o(fail), .adj_count_o(adj)
  );

  phase_edge_align #(.MAX_ADJ(8)) uut_lim (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_l), .cmp_i(cmp_l),
    .phase_o(phase_l), .load_o(load_l), .busy_o(busy_l), .done_o(done_l),
    .fail_o(fail_l), .adj_count_o(adj_l)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic summary_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // run uut once, optionally poke start mid-run; returns when finished
  task automatic run_main(input bit poke);
    @(negedge clk);
    tog = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      if (poke && i == 40) start = 1'b1;
      if (poke && i == 41) start = 1'b0;
      @(negedge clk);
      if (!busy) break;
    end
    if (busy) begin
      n_chk++; n_bad++;
      $display("FAIL R2 run did not finish: actual busy 1 expected 0");
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_ok(input string rq, input int exp_adj, input int exp_ph);
    chk(rq, "done", int'(done), 1);
    chk(rq, "fail", int'(fail), 0);
    chk(rq, "adj_count", int'(adj), exp_adj);
    chk(rq, "final phase", int'(phase), exp_ph);
    chk("R7", "strobe toggles", tog, exp_adj + 1);
  endtask

  task automatic t_reset();
    chk("R1", "phase", int'(phase), 0);
    chk("R1", "load", int'(load), 0);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "fail", int'(fail), 0);
    chk("R1", "adj_count", int'(adj), 0);
  endtask

  // R3 R12: clean edge at 20 from phase 0, start poked mid-run
  task automatic t_clean_far();
    mode = 0; edge_ph = 6'd20; glitch_en = 0; noisy_en = 0;
    run_main(1'b1);
    expect_ok("R3", 39, 19);
    chk("R12", "adj after busy start", int'(adj), 39);
  endtask

  // R10: restart from parked phase
  task automatic t_clean_near();
    run_main(1'b0);
    expect_ok("R10", 20, 19);
  endtask

  // R3: start inside the low region
  task automatic t_from_low();
    edge_ph = 6'd10;
    run_main(1'b0);
    expect_ok("R3", 30, 9);
  endtask

  // R11: wrap below zero
  task automatic t_wrap();
    edge_ph = 6'd0;
    run_main(1'b0);
    expect_ok("R11", 30, 63);
  endtask

  // R4 R8: isolated low glitch gives a false edge, retry succeeds
  task automatic t_false_edge();
    edge_ph = 6'd11; glitch_ph = 6'd1; glitch_en = 1;
    run_main(1'b0);
    expect_ok("R4", 33, 10);
    glitch_en = 0;
  endtask

  // R5 R6: noisy sample in backward pass, retry then rediscovery
  task automatic t_noisy();
    edge_ph = 6'd11; noisy_en = 1;
    run_main(1'b0);
    expect_ok("R5", 26, 10);
    noisy_en = 0;
  endtask

  // R8: alternating comparator exhausts attempts
  task automatic t_attempts();
    mode = 1;
    run_main(1'b0);
    chk("R8", "fail", int'(fail), 1);
    chk("R8", "done", int'(done), 0);
    chk("R8", "adj_count", int'(adj), 40);
    mode = 0;
  endtask

  // R9: adjustment budget of 8 on a long hunt
  task automatic t_budget();
    @(negedge clk);
    start_l = 1'b1;
    @(negedge clk);
    start_l = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!busy_l) break;
    end
    chk("R9", "fail", int'(fail_l), 1);
    chk("R9", "done", int'(done_l), 0);
    chk("R9", "adj_count", int'(adj_l), 8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary_end();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean_far();
    t_clean_near();
    t_from_low();
    t_wrap();
    t_false_edge();
    t_noisy();
    t_attempts();
    t_budget();
    summary_end();
  end
endmodule